// File: doc/BRIEF.md
# Pipelined zero-turnaround synchronous SRAM

This block is a cycle-accurate, synthesizable model of a synchronous SRAM with a fixed two-cycle pipeline. A command is registered on a rising clock edge. Its write data is taken from `wdata` two active edges later, or its read data appears on `rdata` just after that edge. Reads and writes have the same spacing, so the data bus never needs an idle cycle when the direction changes. Each word is 36 bits, split into four 9-bit byte lanes. The depth is a parameter and is small by default.

New accesses load an address, or continue a 4-word burst from the last loaded address. The burst visits its words in linear or interleaved order. Three chip selects, a sleep input and a clock enable decide whether a new access is accepted. A stalled clock enable freezes every register in the block. Accesses that are already in the pipeline finish even when the device is deselected.

The data interface carries no back-pressure. `rvalid` marks the one cycle in which `rdata` holds a read result, and no ready signal exists. The host must supply write data in the exact slot. The only way to hold the flow back is to raise `cke_n`, which stalls both directions together.

Top module: `zbt_sram`

## Requirements
- R1: A command registered at active edge k transfers its data at active edge k+2. A write takes `wdata` at that edge. A read shows its word on `rdata`, with `rvalid` high, from that edge until the next active edge.
- R2: Commands may be issued on every active edge in any mix of reads and writes, with no idle cycles between them, and every transfer keeps the R1 timing.
- R3: While `cke_n` is high, no register or memory word changes, and all other synchronous inputs are ignored. `rdata` and `rvalid` hold their values, provided `oe_n` and `sleep` stay constant.
- R4: A new access is loaded only when `adv` is 0 and all three selects are active (`sel0_n`=0, `sel1`=1, `sel2_n`=0). A load with any select inactive starts nothing, and later `adv`=1 cycles also start nothing. Accesses already in flight still complete.
- R5: On a load, `rd_wr`=1 selects a read and `rd_wr`=0 selects a write. An advance (`adv`=1) repeats the direction of the last load.
- R6: Each advance steps a burst counter n = 1, 2, 3, 0, and so on. The upper address bits stay equal to those of the loaded address. With `order_lin`=1, the two low bits are (start + n) mod 4.
- R7: With `order_lin`=0, the two low bits of the burst address are start XOR n.
- R8: `bwe_n` is sampled with each write command. Bit i low writes `wdata[9i+8:9i]` into lane i. Lanes whose bit is high keep their old content.
- R9: `oe_n` high forces `rvalid` to 0 and `rdata` to 0 at once, without changing the pipeline.
- R10: While `sleep` is high, no access is loaded or advanced, and any burst ends. `rvalid` and `rdata` are forced to 0. Memory contents are kept.
- R11: A read issued one or two cycles after a write to the same address returns the bytes just written.
- R12: After reset, `rvalid` is 0, the pipeline is empty, and every word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers change on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; high stalls the block |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 advances the burst, 0 loads a new address |
| rd_wr | input | 1 | Direction at load: 1 read, 0 write |
| bwe_n | input | 4 | Byte-lane write enables, active low |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request |
| addr | input | AW | Word address |
| wdata | input | 36 | Write data, taken two active edges after its command |
| rdata | output | 36 | Read data; 0 when rvalid is low |
| rvalid | output | 1 | rdata holds a read result |

## Verification
The hardest case to reach from the ports is a `cke_n` stall that lands while a write and a read to the same word sit in adjacent pipeline stages. Here the forwarding path and the frozen pipeline interact. Other hard cases are a deselect or sleep that arrives in the middle of a burst.

Directed sequences build each of these cases on purpose. A long seeded random run then mixes stalls, partial selects, sleeps, advances and byte masks over a 16-word space. In that space, writes followed by reads of the same word happen often.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_e;

  // Low two address bits of burst beat n from a given start
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] n,
                                           input logic       lin);
    return lin ? 2'(start + n) : (start ^ n);
  endfunction

endpackage

// File: rtl/zbt_cmd.sv
module zbt_cmd
  import zbt_pkg::*;
#(
  parameter int AW    = 4,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_n,
  input  logic             sel_ok,
  input  logic             adv,
  input  logic             rd_wr,
  input  logic             order_lin,
  input  logic             sleep,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] bwe_n,
  output logic             c1_vld,
  output logic             c1_wr,
  output logic [AW-1:0]    c1_addr,
  output logic [LANES-1:0] c1_bw
);

  seq_e          seq_q, seq_d;
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;
  logic          iss_vld, iss_wr;
  logic [AW-1:0] iss_addr;

  always_comb begin
    seq_d    = seq_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    iss_vld  = 1'b0;
    iss_wr   = 1'b0;
    iss_addr = addr;
    if (sleep) begin
      seq_d = SEQ_IDLE;
    end else if (!adv) begin
      if (sel_ok) begin
        iss_vld = 1'b1;
        iss_wr  = !rd_wr;
        seq_d   = rd_wr ? SEQ_READ : SEQ_WRITE;
        base_d  = addr;
        cnt_d   = 2'd0;
      end else begin
        seq_d = SEQ_IDLE;
      end
    end else if (seq_q != SEQ_IDLE) begin
      cnt_d    = cnt_q + 2'd1;
      iss_vld  = 1'b1;
      iss_wr   = (seq_q == SEQ_WRITE);
      iss_addr = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_d, order_lin)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q   <= SEQ_IDLE;
      base_q  <= '0;
      cnt_q   <= '0;
      c1_vld  <= 1'b0;
      c1_wr   <= 1'b0;
      c1_addr <= '0;
      c1_bw   <= '0;
    end else if (!cke_n) begin
      seq_q   <= seq_d;
      base_q  <= base_d;
      cnt_q   <= cnt_d;
      c1_vld  <= iss_vld;
      c1_wr   <= iss_wr;
      c1_addr <= iss_addr;
      c1_bw   <= ~bwe_n;
    end
  end

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int AW    = 4,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cke_n,
  input  logic                c1_vld,
  input  logic                c1_wr,
  input  logic [AW-1:0]       c1_addr,
  input  logic [LANES-1:0]    c1_bw,
  input  logic [LANES*LW-1:0] wdata,
  output logic                out_vld,
  output logic [LANES*LW-1:0] out_q,
  output logic                mem_we
);

  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic             c2_vld, c2_wr;
  logic [AW-1:0]    c2_addr;
  logic [LANES-1:0] c2_bw;
  logic [DW-1:0]    rd_q, rd_fwd, wr_merged;
  logic             same_word;

  assign mem_we    = !cke_n && c2_vld && c2_wr;
  assign same_word = mem_we && (c2_addr == c1_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wr_merged[l*LW +: LW] = c2_bw[l] ? wdata[l*LW +: LW]
                                            : mem[c2_addr][l*LW +: LW];
    // forward the write that retires on this edge into the read being fetched
    assign rd_fwd[l*LW +: LW] = (same_word && c2_bw[l]) ? wdata[l*LW +: LW]
                                                        : mem[c1_addr][l*LW +: LW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_vld  <= 1'b0;
      c2_wr   <= 1'b0;
      c2_addr <= '0;
      c2_bw   <= '0;
      rd_q    <= '0;
      out_vld <= 1'b0;
      out_q   <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (!cke_n) begin
      c2_vld  <= c1_vld;
      c2_wr   <= c1_wr;
      c2_addr <= c1_addr;
      c2_bw   <= c1_bw;
      rd_q    <= rd_fwd;
      out_vld <= c2_vld && !c2_wr;
      out_q   <= rd_q;
      if (mem_we) mem[c2_addr] <= wr_merged;
    end
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int AW    = 4,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cke_n,
  input  logic                sel0_n,
  input  logic                sel1,
  input  logic                sel2_n,
  input  logic                adv,
  input  logic                rd_wr,
  input  logic [LANES-1:0]    bwe_n,
  input  logic                order_lin,
  input  logic                oe_n,
  input  logic                sleep,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] wdata,
  output logic [LANES*LW-1:0] rdata,
  output logic                rvalid
);

  localparam int DW = LANES * LW;

  logic             sel_ok;
  logic             c1_vld, c1_wr;
  logic [AW-1:0]    c1_addr;
  logic [LANES-1:0] c1_bw;
  logic             out_vld, mem_we;
  logic [DW-1:0]    out_q;

  assign sel_ok = !sel0_n && sel1 && !sel2_n;

  zbt_cmd #(.AW(AW), .LANES(LANES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel_ok(sel_ok), .adv(adv),
    .rd_wr(rd_wr), .order_lin(order_lin), .sleep(sleep), .addr(addr),
    .bwe_n(bwe_n), .c1_vld(c1_vld), .c1_wr(c1_wr), .c1_addr(c1_addr),
    .c1_bw(c1_bw)
  );

  zbt_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .c1_vld(c1_vld), .c1_wr(c1_wr),
    .c1_addr(c1_addr), .c1_bw(c1_bw), .wdata(wdata), .out_vld(out_vld),
    .out_q(out_q), .mem_we(mem_we)
  );

  assign rvalid = out_vld && !oe_n && !sleep;
  assign rdata  = rvalid ? out_q : '0;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke_n,
  input logic          adv,
  input logic          sel0_n,
  input logic          sel1,
  input logic          sel2_n,
  input logic          sleep,
  input logic          oe_n,
  input logic          rvalid,
  input logic [DW-1:0] rdata,
  input logic          c1_vld,
  input logic          out_vld,
  input logic [DW-1:0] out_q
);

  AST_OE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rvalid && rdata == '0)); // R9

  AST_STALL_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(out_vld) && $stable(out_q))); // R3

  AST_STALL_HOLDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(c1_vld)); // R3

  AST_DESELECT_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv && (sel0_n || !sel1 || sel2_n)) |=> !c1_vld); // R4

  AST_SLEEP_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && sleep) |=> !c1_vld); // R10

endmodule

bind zbt_sram zbt_sram_chk #(.DW(LANES*LW)) u_chk (.*);

// File: tb/zbt_sram_test.sv
module zbt_sram_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke_n = 1'b0, sel0_n = 1'b0, sel1 = 1'b1, sel2_n = 1'b0;
  logic        adv = 1'b0, rd_wr = 1'b1, order_lin = 1'b1, oe_n = 1'b0, sleep = 1'b0;
  logic [3:0]  bwe_n = 4'h0;
  logic [3:0]  addr = 4'h0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        rvalid;

  int errs = 0, checks = 0;
  string cur_req = "R12";

  // reference state
  logic [35:0] mmem [16];
  int          mseq = 0;
  logic [3:0]  mbase = '0;
  logic [1:0]  mcnt = '0;
  logic        p1v = 0, p1w = 0, p2v = 0, p2w = 0, ev = 0;
  logic [3:0]  p1a = '0, p2a = '0, p1bw = '0, p2bw = '0;
  logic [35:0] eq = '0;

  zbt_sram uut (.clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel0_n(sel0_n),
    .sel1(sel1), .sel2_n(sel2_n), .adv(adv), .rd_wr(rd_wr), .bwe_n(bwe_n),
    .order_lin(order_lin), .oe_n(oe_n), .sleep(sleep), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic iv, iw;
    logic [3:0] ia;
    if (cke_n) return;
    ev = p2v && !p2w;
    if (ev) eq = mmem[p2a];
    if (p2v && p2w)
      for (int l = 0; l < 4; l++) if (p2bw[l]) mmem[p2a][l*9 +: 9] = wdata[l*9 +: 9];
    iv = 0; iw = 0; ia = addr;
    if (sleep) mseq = 0;
    else if (!adv) begin
      if (!sel0_n && sel1 && !sel2_n) begin
        iv = 1; iw = !rd_wr; mseq = rd_wr ? 1 : 2; mbase = addr; mcnt = 0;
      end else mseq = 0;
    end else if (mseq != 0) begin
      mcnt = mcnt + 2'd1; iv = 1; iw = (mseq == 2);
      ia = {mbase[3:2], order_lin ? 2'(mbase[1:0] + mcnt) : (mbase[1:0] ^ mcnt)};
    end
    p2v = p1v; p2w = p1w; p2a = p1a; p2bw = p1bw;
    p1v = iv; p1w = iw; p1a = ia; p1bw = ~bwe_n;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    begin
      logic v;
      v = ev && !oe_n && !sleep;
      chk({cur_req, " rvalid"}, {35'd0, rvalid}, {35'd0, v});
      chk({cur_req, " rdata"}, rdata, v ? eq : 36'd0);
    end
  endtask

  task automatic op(input logic ld, input logic rd, input logic [3:0] a,
                    input logic [3:0] bwn, input logic [35:0] wd);
    adv = !ld; rd_wr = rd; addr = a; bwe_n = bwn; wdata = wd;
    cyc();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      sel0_n = 1'b1; adv = 1'b0; cyc(); sel0_n = 1'b0;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int sd;
    for (int i = 0; i < 16; i++) mmem[i] = '0;
    sd = $urandom(32'h5eed_2001);
    // R12 reset state
    #(CLK_NS * 3);
    @(negedge clk);
    chk("R12 reset rvalid", {35'd0, rvalid}, 36'd0);
    rst_n = 1'b1;
    cur_req = "R12"; op(1, 1, 4'd5, 4'h0, '0); idle(2);

    // R1 R5 R11: write then read same word next cycle and two cycles later
    cur_req = "R11";
    op(1, 0, 4'd3, 4'h0, '0);
    op(1, 1, 4'd3, 4'h0, '0);
    op(1, 1, 4'd3, 4'h0, 36'h1_2345_6789);
    op(1, 1, 4'd3, 4'h0, 36'h0);
    idle(2);
    // R2 alternating directions with no gap
    cur_req = "R2";
    for (int i = 0; i < 8; i++) op(1, i[0], 4'(i), 4'h0, {4'(i), 32'hA5A5_0000 + 32'(i)});
    idle(3);
    // R3 stall in the middle of a write/read pair
    cur_req = "R3";
    op(1, 0, 4'd7, 4'h0, '0);
    op(1, 1, 4'd7, 4'h0, '0);
    cke_n = 1'b1;
    for (int i = 0; i < 3; i++) op(1, 0, 4'd7, 4'h0, 36'hF_FFFF_FFFF);
    cke_n = 1'b0;
    op(1, 1, 4'd7, 4'h0, 36'h9_8765_4321);
    op(1, 1, 4'd7, 4'h0, '0);
    cke_n = 1'b1; op(1, 1, 4'd7, 4'h0, '0); op(1, 1, 4'd7, 4'h0, '0); cke_n = 1'b0;
    idle(3);
    // R4 deselect while a write is in flight, then advances stay idle
    cur_req = "R4";
    op(1, 0, 4'd9, 4'h0, '0);
    sel1 = 1'b0; op(1, 0, 4'd10, 4'h0, 36'h3_3333_3333);
    sel1 = 1'b1; op(0, 0, 4'd11, 4'h0, 36'h4_4444_4444);
    op(0, 0, 4'd12, 4'h0, 36'h5_5555_5555);
    op(1, 1, 4'd9, 4'h0, '0); op(1, 1, 4'd10, 4'h0, '0); op(1, 1, 4'd11, 4'h0, '0);
    idle(3);
    // R6 linear burst write from start 2, burst read back
    cur_req = "R6"; order_lin = 1'b1;
    op(1, 0, 4'd6, 4'h0, '0);
    for (int i = 0; i < 5; i++) op(0, 0, 4'd0, 4'h0, 36'h6_0000_0000 + 36'(i));
    op(1, 1, 4'd6, 4'h0, 36'h6_0000_0005); op(1, 1, 4'd6, 4'h0, 36'h6_0000_0006);
    for (int i = 0; i < 4; i++) op(0, 0, 4'd0, 4'h0, '0);
    idle(3);
    // R7 interleaved burst from start 1
    cur_req = "R7"; order_lin = 1'b0;
    op(1, 0, 4'd13, 4'h0, '0);
    for (int i = 0; i < 3; i++) op(0, 1, 4'd0, 4'h0, 36'h7_0000_0010 + 36'(i));
    op(1, 1, 4'd13, 4'h0, 36'h7_0000_0013); op(1, 1, 4'd13, 4'h0, 36'h7_0000_0014);
    for (int i = 0; i < 3; i++) op(0, 0, 4'd0, 4'h0, '0);
    idle(3); order_lin = 1'b1;
    // R8 partial byte writes
    cur_req = "R8";
    op(1, 0, 4'd2, 4'h0, '0); op(1, 0, 4'd2, 4'hA, '0);
    op(1, 1, 4'd2, 4'h0, 36'h1_1111_1111); op(1, 1, 4'd2, 4'h0, 36'hE_EEEE_EEEE);
    idle(3);
    // R9 output enable off while a read is presented
    cur_req = "R9";
    op(1, 1, 4'd2, 4'h0, '0); op(1, 1, 4'd3, 4'h0, '0);
    oe_n = 1'b1; idle(1); oe_n = 1'b0; idle(1);
    // R10 sleep during a burst
    cur_req = "R10";
    op(1, 1, 4'd4, 4'h0, '0); sleep = 1'b1;
    op(0, 0, 4'd0, 4'h0, '0); op(1, 0, 4'd2, 4'h0, 36'hD_DDDD_DDDD);
    sleep = 1'b0; op(0, 0, 4'd0, 4'h0, '0);
    op(1, 1, 4'd2, 4'h0, '0); idle(3);
    // R2 seeded random mix
    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      cke_n     = ($urandom % 8) == 0;
      adv       = ($urandom % 3) == 0;
      rd_wr     = $urandom % 2;
      sel0_n    = ($urandom % 12) == 0;
      sel1      = ($urandom % 12) != 0;
      sel2_n    = ($urandom % 12) == 0;
      oe_n      = ($urandom % 10) == 0;
      sleep     = ($urandom % 20) == 0;
      bwe_n     = 4'($urandom);
      addr      = 4'($urandom);
      wdata     = {4'($urandom), 32'($urandom)};
      if (i % 500 == 0) order_lin = ~order_lin;
      cyc();
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule